// File: doc/BRIEF.md
# Pulse-Distance Infrared Frame Encoder

This block produces the carrier-enable envelope for a pulse-distance infrared remote-control frame. A frame starts with a long header mark and a header space. A preamble word and then a command word follow, each sent least significant bit first. Every bit is a short mark followed by a space whose length carries the bit value. A short trailer mark closes the frame, and a fixed silent gap follows it. The block then returns to idle. All timing is counted in ticks of an external timebase, so the same logic serves any carrier or unit rate.

Software-facing logic presents a 32-bit request word with a start strobe. A repeat strobe resends the stored command. A stop request clears the stored command once the frame in flight has finished. The preamble value and the long bit count come from configuration inputs; a typical preamble is 0x00A02002 with a count of 24. The modulation-enable output gates an external carrier generator, and the idle and busy levels report whether a frame is under way.

Top module: `irpd_frame_tx`

## Requirements
- R1: During and just after reset, mod_en is 0, idle is 1 and busy is 0.
- R2: A frame opens with a mark of 128 ticks (mod_en 1), then a header space of 51 ticks (mod_en 0).
- R3: Every data bit is a 13-tick mark. A 0 bit is followed by a 13-tick space and a 1 bit by a 38-tick space.
- R4: The preamble (cfg_preamble) is sent first and the stored command second. Each word is sent bit 0 first, for the frame's bit count, and one bit counter serves both words.
- R5: On a start, request bit 31 = 1 selects a bit count of cfg_nbits and bit 31 = 0 selects zero. The stored command takes request bits 27:0, with bits 31:28 forced to 0. A start whose masked command is zero launches nothing.
- R6: With a bit count of zero, the header space is followed directly by the trailer mark.
- R7: After the last space comes a 13-tick trailer mark. Then mod_en stays 0 for 187 units of 13 ticks (2431 ticks), after which idle returns to 1 and busy to 0.
- R8: A start or repeat launches a frame only while idle and with a nonzero command. A start or repeat while busy is ignored, and the stored command is kept.
- R9: A stop while busy does not disturb the frame in flight. The stored command is cleared when the block is next idle, and a stop while idle clears it at once. Stop takes priority over a start or repeat in the same cycle.
- R10: Segment timing advances only on tick cycles. mod_en goes high on the clock edge that captures an accepted start or repeat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timebase enable, one tick per cycle it is high |
| req_word | input | 32 | Request word: bit 31 is the count flag, bits 27:0 are the command |
| req_start | input | 1 | Load req_word and launch a frame |
| req_repeat | input | 1 | Resend the stored command |
| req_stop | input | 1 | Clear the stored command once idle |
| cfg_preamble | input | 32 | Preamble word sent before the command |
| cfg_nbits | input | 6 | Bit count selected when request bit 31 is set |
| mod_en | output | 1 | Carrier enable, registered |
| idle | output | 1 | No frame in progress |
| busy | output | 1 | Frame in progress |

## Verification
mod_en is due on the first clock edge after a strobe is raised, because that edge captures the strobe. The bench samples it one half-cycle later, having first confirmed that it is still low in the half-cycle before. Every later boundary falls on the edge that consumes a segment's final tick. The monitor therefore samples at the falling edge, counts the tick cycles spent at each mod_en level, and closes the last silent run when idle rises. Each run's tick count is then compared with the queued expectation, so the checks hold for any tick spacing. Ignored requests are judged by holding idle and mod_en under observation for a window after the strobe.

// File: rtl/irpd_pkg.sv
package irpd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_HMARK  = 3'd1,
    ST_HSPACE = 3'd2,
    ST_BMARK  = 3'd3,
    ST_BSPACE = 3'd4,
    ST_TRAIL  = 3'd5,
    ST_GAP    = 3'd6
  } irpd_state_e;

  // carrier is on in every mark segment
  function automatic logic is_mark(irpd_state_e s);
    return (s == ST_HMARK) || (s == ST_BMARK) || (s == ST_TRAIL);
  endfunction

  // space length carries the bit value
  function automatic int unsigned space_ticks(logic b, int unsigned t_zero, int unsigned t_one);
    return b ? t_one : t_zero;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/irpd_seg_timer.sv
module irpd_seg_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             seg_done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (load)                cnt_q <= load_val;
    else if (tick && cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
  end

  // the final tick of a segment
  assign seg_done = tick && (cnt_q == '0);
endmodule

// File: rtl/irpd_cmd_store.sv
module irpd_cmd_store #(
  parameter int WORD_W   = 32,
  parameter int KEEP_W   = 28,
  parameter int FLAG_BIT = 31,
  parameter int NB_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle,
  input  logic [WORD_W-1:0] req_word,
  input  logic              req_start,
  input  logic              req_repeat,
  input  logic              req_stop,
  input  logic [NB_W-1:0]   cfg_nbits,
  output logic              go,
  output logic [NB_W-1:0]   launch_nbits,
  output logic [WORD_W-1:0] cmd_word,
  output logic              cmd_nz
);
  logic [WORD_W-1:0] cmd_q, new_cmd;
  logic [NB_W-1:0]   nb_q, new_nb;
  logic              stop_pend_q, stop_now, take_start;

  always_comb begin
    new_cmd = '0;
    new_cmd[KEEP_W-1:0] = req_word[KEEP_W-1:0];
  end
  assign new_nb       = req_word[FLAG_BIT] ? cfg_nbits : '0;
  assign stop_now     = idle && (req_stop || stop_pend_q);
  assign take_start   = idle && req_start && !stop_now;
  assign go           = idle && !stop_now &&
                        (req_start ? (new_cmd != '0) : (req_repeat && cmd_q != '0));
  assign launch_nbits = req_start ? new_nb : nb_q;
  assign cmd_word     = cmd_q;
  assign cmd_nz       = (cmd_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q       <= '0;
      nb_q        <= '0;
      stop_pend_q <= 1'b0;
    end else if (stop_now) begin
      cmd_q       <= '0;
      nb_q        <= '0;
      stop_pend_q <= 1'b0;
    end else begin
      if (take_start) begin
        cmd_q <= new_cmd;
        nb_q  <= new_nb;
      end
      if (req_stop && !idle) stop_pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/irpd_seq.sv
module irpd_seq
  import irpd_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NB_W      = 6,
  parameter int CNT_W     = 8,
  parameter int GAP_W     = 8,
  parameter int HDR_MARK  = 128,
  parameter int HDR_SPACE = 51,
  parameter int UNIT      = 13,
  parameter int ONE_SPACE = 38,
  parameter int GAP_UNITS = 187
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [NB_W-1:0]   launch_nbits,
  input  logic [WORD_W-1:0] preamble,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              seg_done,
  output irpd_state_e       state,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  output logic              mod_en
);
  irpd_state_e       state_q, state_d;
  logic [WORD_W-1:0] work_q, work_d;
  logic [NB_W-1:0]   bitc_q, bitc_d, nb_q, nb_d;
  logic              in_cmd_q, in_cmd_d, mod_q, last_bit;
  logic [GAP_W-1:0]  gap_q, gap_d;

  assign last_bit = ((bitc_q + NB_W'(1)) == nb_q);

  always_comb begin
    state_d  = state_q;
    work_d   = work_q;
    bitc_d   = bitc_q;
    nb_d     = nb_q;
    in_cmd_d = in_cmd_q;
    gap_d    = gap_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE: if (go) begin
        state_d  = ST_HMARK;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(HDR_MARK - 1);
        work_d   = preamble;
        bitc_d   = '0;
        nb_d     = launch_nbits;
        in_cmd_d = 1'b0;
        gap_d    = '0;
      end
      ST_HMARK: if (seg_done) begin
        state_d  = ST_HSPACE;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(HDR_SPACE - 1);
      end
      ST_HSPACE: if (seg_done) begin
        state_d  = (nb_q == '0) ? ST_TRAIL : ST_BMARK;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(UNIT - 1);
      end
      ST_BMARK: if (seg_done) begin
        state_d  = ST_BSPACE;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(space_ticks(work_q[0], UNIT, ONE_SPACE) - 1);
      end
      ST_BSPACE: if (seg_done) begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(UNIT - 1);
        work_d   = work_q >> 1;
        if (!last_bit) begin
          bitc_d  = bitc_q + NB_W'(1);
          state_d = ST_BMARK;
        end else begin
          bitc_d = '0;
          if (!in_cmd_q) begin
            in_cmd_d = 1'b1;
            work_d   = cmd_word;
            state_d  = ST_BMARK;
          end else begin
            state_d = ST_TRAIL;
          end
        end
      end
      ST_TRAIL: if (seg_done) begin
        state_d  = ST_GAP;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(UNIT - 1);
        gap_d    = '0;
      end
      ST_GAP: if (seg_done) begin
        if (gap_q == GAP_W'(GAP_UNITS - 1)) begin
          state_d = ST_IDLE;
          gap_d   = '0;
        end else begin
          gap_d    = gap_q + GAP_W'(1);
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(UNIT - 1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      work_q   <= '0;
      bitc_q   <= '0;
      nb_q     <= '0;
      in_cmd_q <= 1'b0;
      gap_q    <= '0;
      mod_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      work_q   <= work_d;
      bitc_q   <= bitc_d;
      nb_q     <= nb_d;
      in_cmd_q <= in_cmd_d;
      gap_q    <= gap_d;
      mod_q    <= is_mark(state_d);
    end
  end

  assign state  = state_q;
  assign mod_en = mod_q;
endmodule

// File: rtl/irpd_frame_tx.sv
module irpd_frame_tx
  import irpd_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int KEEP_W    = 28,
  parameter int FLAG_BIT  = 31,
  parameter int NB_W      = 6,
  parameter int HDR_MARK  = 128,
  parameter int HDR_SPACE = 51,
  parameter int UNIT      = 13,
  parameter int ONE_SPACE = 38,
  parameter int GAP_UNITS = 187
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [WORD_W-1:0] req_word,
  input  logic              req_start,
  input  logic              req_repeat,
  input  logic              req_stop,
  input  logic [WORD_W-1:0] cfg_preamble,
  input  logic [NB_W-1:0]   cfg_nbits,
  output logic              mod_en,
  output logic              idle,
  output logic              busy
);
  localparam int MAX_DUR = max3(HDR_MARK, HDR_SPACE, ONE_SPACE);
  localparam int CNT_W   = $clog2(MAX_DUR + 1);
  localparam int GAP_W   = $clog2(GAP_UNITS + 1);

  // named internal events, used by the bound checker
  irpd_state_e       state_w;
  logic              go_w, seg_done_w, cmd_nz_w, in_gap_w, tmr_load_w;
  logic [CNT_W-1:0]  tmr_val_w;
  logic [NB_W-1:0]   launch_nb_w;
  logic [WORD_W-1:0] cmd_word_w;

  irpd_cmd_store #(
    .WORD_W(WORD_W), .KEEP_W(KEEP_W), .FLAG_BIT(FLAG_BIT), .NB_W(NB_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .idle(idle), .req_word(req_word),
    .req_start(req_start), .req_repeat(req_repeat), .req_stop(req_stop),
    .cfg_nbits(cfg_nbits), .go(go_w), .launch_nbits(launch_nb_w),
    .cmd_word(cmd_word_w), .cmd_nz(cmd_nz_w)
  );

  irpd_seg_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(tmr_load_w),
    .load_val(tmr_val_w), .seg_done(seg_done_w)
  );

  irpd_seq #(
    .WORD_W(WORD_W), .NB_W(NB_W), .CNT_W(CNT_W), .GAP_W(GAP_W),
    .HDR_MARK(HDR_MARK), .HDR_SPACE(HDR_SPACE), .UNIT(UNIT),
    .ONE_SPACE(ONE_SPACE), .GAP_UNITS(GAP_UNITS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go_w), .launch_nbits(launch_nb_w),
    .preamble(cfg_preamble), .cmd_word(cmd_word_w), .seg_done(seg_done_w),
    .state(state_w), .tmr_load(tmr_load_w), .tmr_val(tmr_val_w), .mod_en(mod_en)
  );

  assign idle     = (state_w == ST_IDLE);
  assign busy     = !idle;
  assign in_gap_w = (state_w == ST_GAP);
endmodule

// File: rtl/irpd_frame_tx_chk.sv
module irpd_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic req_start,
  input logic req_repeat,
  input logic req_stop,
  input logic mod_en,
  input logic idle,
  input logic busy,
  input logic go,
  input logic cmd_nz,
  input logic in_gap
);
  p_idle_mod_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !mod_en);

  p_gap_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_gap |-> !mod_en);

  p_launch_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && go) |=> (busy && mod_en));

  p_no_launch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !go) |=> idle);

  p_empty_repeat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && req_repeat && !req_start && !cmd_nz) |=> idle);

  p_stop_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && req_stop) |=> !cmd_nz);

  p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> ($stable(mod_en) && busy));
endmodule

bind irpd_frame_tx irpd_frame_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .req_start(req_start),
  .req_repeat(req_repeat), .req_stop(req_stop), .mod_en(mod_en),
  .idle(idle), .busy(busy), .go(go_w), .cmd_nz(cmd_nz_w), .in_gap(in_gap_w)
);

// File: tb/sim_irpd_frame_tx.sv
module sim_irpd_frame_tx;
  localparam int CLK_PERIOD = 10;
  localparam int T_HM = 128, T_HS = 51, T_U = 13, T_ONE = 38, N_GAP = 187;
  localparam logic [31:0] PRE = 32'h00A02002;

  logic clk, rst_n, tick, req_start, req_repeat, req_stop;
  logic [31:0] req_word, cfg_preamble;
  logic [5:0]  cfg_nbits;
  logic mod_en, idle, busy;

  irpd_frame_tx u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req_word(req_word),
    .req_start(req_start), .req_repeat(req_repeat), .req_stop(req_stop),
    .cfg_preamble(cfg_preamble), .cfg_nbits(cfg_nbits),
    .mod_en(mod_en), .idle(idle), .busy(busy)
  );

  initial begin clk = 0; forever #(CLK_PERIOD/2) clk = ~clk; end

  int n_checks = 0, n_fail = 0, frames_done = 0, tick_div = 1;
  bit mon_en = 0;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // scoreboard queue of expected segments
  int q_lvl[$]; int q_len[$]; string q_tag[$];

  task automatic push_seg(int lvl, int len, string tag);
    q_lvl.push_back(lvl); q_len.push_back(len); q_tag.push_back(tag);
  endtask

  task automatic push_word(logic [31:0] w, int nb);
    for (int i = 0; i < nb; i++) begin
      push_seg(1, T_U, "R3");
      push_seg(0, w[i] ? T_ONE : T_U, "R4");
    end
  endtask

  task automatic push_frame(logic [31:0] cmd, int nb);
    push_seg(1, T_HM, "R2");
    push_seg(0, T_HS, "R2");
    push_word(PRE, nb);
    push_word(cmd, nb);
    push_seg(1, T_U, (nb == 0) ? "R6" : "R7");
    push_seg(0, N_GAP * T_U, "R7");
  endtask

  // monitor: tick count per mod_en level run, compared against the queue
  bit in_frame = 0; int run_lvl = 0; int run_ticks = 0;

  task automatic close_run();
    if (q_lvl.size() == 0)
      check(0, "R4", "unexpected segment lvl*100000+ticks", run_lvl*100000 + run_ticks, -1);
    else begin
      int el, ln; string tg;
      el = q_lvl.pop_front(); ln = q_len.pop_front(); tg = q_tag.pop_front();
      check(run_lvl == el && run_ticks == ln, tg, "segment lvl*100000+ticks",
            run_lvl*100000 + run_ticks, el*100000 + ln);
    end
  endtask

  always @(negedge clk) if (mon_en) begin
    if (idle) begin
      if (in_frame) begin close_run(); in_frame = 0; frames_done++; end
    end else begin
      if (!in_frame) begin in_frame = 1; run_lvl = mod_en; run_ticks = 0; end
      else if (int'(mod_en) != run_lvl) begin close_run(); run_lvl = mod_en; run_ticks = 0; end
      if (tick) run_ticks++;
    end
  end

  // timebase driver
  initial begin
    int ph = 0;
    tick = 0;
    forever begin
      @(posedge clk); #1;
      if (tick_div <= 1) tick = 1;
      else begin tick = (ph == 0); ph = (ph + 1 >= tick_div) ? 0 : ph + 1; end
    end
  end

  // kind: 0 start, 1 repeat, 2 stop; launch: 1 expect frame, 0 expect none, -1 no check
  task automatic strobe(int kind, logic [31:0] w, int launch, string tag);
    @(posedge clk); #1;
    req_word = w;
    case (kind)
      0: req_start = 1;
      1: req_repeat = 1;
      default: req_stop = 1;
    endcase
    if (launch == 1) begin
      @(negedge clk);
      check(mod_en == 0, "R10", "mod_en before capture edge", mod_en, 0);
    end
    @(posedge clk); #1;
    req_start = 0; req_repeat = 0; req_stop = 0;
    if (launch == 1) begin
      @(negedge clk);
      check(mod_en == 1, tag, "mod_en after capture edge", mod_en, 1);
    end
  endtask

  task automatic hold_idle(int n, string tag);
    bit seen = 0;
    repeat (n) begin @(negedge clk); if (!idle || mod_en) seen = 1; end
    check(!seen, tag, "left idle after ignored request", seen, 0);
  endtask

  task automatic wait_frames(int n);
    while (frames_done < n) @(posedge clk);
    @(negedge clk);
    check(q_lvl.size() == 0, "R4", "pending expected segments", q_lvl.size(), 0);
    check(idle && !busy && !mod_en, "R7", "idle after gap", {idle, busy, mod_en}, 3'b100);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "R7", "watchdog expired", 0, 1);
    report();
  end

  initial begin
    rst_n = 0; req_word = 0; req_start = 0; req_repeat = 0; req_stop = 0;
    cfg_preamble = PRE; cfg_nbits = 6'd24;
    repeat (4) @(negedge clk);
    check(mod_en == 0 && idle && !busy, "R1", "outputs in reset", {mod_en, idle, busy}, 3'b010);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    check(mod_en == 0 && idle && !busy, "R1", "outputs after reset", {mod_en, idle, busy}, 3'b010);
    mon_en = 1;

    // full frame, 24 bits (R2 R3 R4 R5 R7)
    push_frame(32'h0123456, 24);
    strobe(0, 32'h80123456, 1, "R10");
    wait_frames(1);

    // repeat resends stored command (R8)
    push_frame(32'h0123456, 24);
    strobe(1, 32'h0, 1, "R8");
    wait_frames(2);

    // flag clear: zero bits, header straight to trailer (R5 R6)
    push_frame(32'h5, 0);
    strobe(0, 32'h00000005, 1, "R6");
    wait_frames(3);

    // only masked-off bits: no frame, then empty repeat (R5 R8)
    strobe(0, 32'hF0000000, 0, "R5");
    hold_idle(40, "R5");
    strobe(1, 32'h0, 0, "R8");
    hold_idle(40, "R8");

    // top bits masked, 8-bit count; requests while busy ignored (R5 R8)
    cfg_nbits = 6'd8;
    push_frame(32'hA5, 8);
    strobe(0, 32'hF00000A5, 1, "R5");
    repeat (300) @(posedge clk);
    strobe(0, 32'h800000FF, -1, "R8");
    strobe(1, 32'h0, -1, "R8");
    wait_frames(4);
    push_frame(32'hA5, 8);
    strobe(1, 32'h0, 1, "R8");
    wait_frames(5);

    // stop while busy: frame completes, then command gone (R9)
    push_frame(32'hA5, 8);
    strobe(1, 32'h0, 1, "R8");
    repeat (100) @(posedge clk);
    strobe(2, 32'h0, -1, "R9");
    @(negedge clk);
    check(busy == 1, "R9", "busy after deferred stop", busy, 1);
    wait_frames(6);
    strobe(1, 32'h0, 0, "R9");
    hold_idle(40, "R9");

    // sparse ticks: durations counted in ticks (R10)
    tick_div = 3; cfg_nbits = 6'd4;
    push_frame(32'hC, 4);
    strobe(0, 32'h8000000C, 1, "R10");
    wait_frames(7);

    // stop while idle clears at once; stop wins over same-cycle start (R9)
    strobe(2, 32'h0, 0, "R9");
    strobe(1, 32'h0, 0, "R9");
    hold_idle(30, "R9");
    @(posedge clk); #1;
    req_word = 32'h8000000C; req_start = 1; req_stop = 1;
    @(posedge clk); #1;
    req_start = 0; req_stop = 0;
    hold_idle(30, "R9");

    report();
  end
endmodule